// File: doc/BRIEF.md
# Saturating Arithmetic Barrel Shifter

This block shifts a 32-bit signed operand by a signed count and can clamp the result when a left shift overflows. A single unit serves both directions. A positive count shifts left. A negative count shifts right arithmetically, so the sign bit is copied into the vacated high bits. A zero count leaves the operand unchanged.

When saturation is enabled, a left shift whose true result does not fit in 32 signed bits is replaced by the nearest representable extreme. When saturation is disabled, the high bits are simply dropped. In both modes an overflow flag reports that the left shift lost significant bits.

The count decoder sorts every request into one of three directions. `SH_HOLD` is a zero count, `SH_LEFT` a positive count and `SH_RIGHT` a negative count. The shift paths and the result select act on that direction. An optional register stage, selected by a parameter, holds the result and the flag.

Top module: `sat_ashift`

## Requirements
- R1: Only the low 6 bits of `count` are used, read as a two's-complement value from -32 to +31. Bits 15:6 have no effect on `result` or `ovf`.
- R2: A negative count shifts the operand right by its magnitude and fills the vacated bits with bit 31. A magnitude of 32 gives all zeros for a non-negative operand and all ones for a negative operand.
- R3: With `sat_en`=1, a left shift whose true value fits the signed 32-bit range returns exactly that shifted value, with `ovf`=0.
- R4: With `sat_en`=1, an overflowing left shift returns 0x7FFFFFFF when operand bit 31 is 0, and 0x80000000 when operand bit 31 is 1.
- R5: `ovf`=1 only for a left shift in which any shifted-out bit, or the new bit 31, differs from the original bit 31. A right shift never sets `ovf`.
- R6: With `sat_en`=0, a left shift returns the low 32 bits of the shifted value. `ovf` is still set under the R5 rule.
- R7: A count whose low 6 bits are zero returns the operand unchanged, with `ovf`=0.
- R8: With OUT_REG=1, `result` and `ovf` show the response to the inputs sampled at a rising `clk` edge, just after that edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| operand | input | 32 | Signed value to shift |
| count | input | 16 | Signed shift count; only the low 6 bits are used |
| sat_en | input | 1 | 1 clamps overflowing left shifts |
| result | output | 32 | Shifted or clamped value |
| ovf | output | 1 | Left-shift overflow indicator |

## Verification
The bench builds the block with its default parameters: a 32-bit operand, a 16-bit count of which 6 bits are used, and the output register present. With these values the whole count range from -32 to +31 is small enough to sweep exhaustively against a 64-bit reference. The sweep runs with operands at both signed extremes, near the overflow threshold, zero and all-ones, in both saturation modes. This reaches the sign-fill case at magnitude 32, the exact-fit left shifts just below the clamp, and the one-cycle register latency.

// File: rtl/sash_pkg.sv
package sash_pkg;

    // Direction decided from the signed count field
    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2
    } shift_dir_e;

endpackage

// File: rtl/sash_count_decode.sv
module sash_count_decode
    import sash_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CNT_USE = 6
) (
    input  logic [CNT_W-1:0]   count,
    output shift_dir_e         dir,
    output logic [CNT_USE-1:0] mag
);

    logic [CNT_USE-1:0]       field;
    logic [CNT_W-CNT_USE-1:0] unused_hi;

    assign field     = count[CNT_USE-1:0];
    assign unused_hi = count[CNT_W-1:CNT_USE];

    // Magnitude in plain binary; the most negative value maps to 2**(CNT_USE-1)
    always_comb begin
        if (field[CNT_USE-1]) begin
            mag = ~field + CNT_USE'(1);
        end else begin
            mag = field;
        end
    end

    always_comb begin
        if (field == '0) begin
            dir = SH_HOLD;
        end else if (field[CNT_USE-1]) begin
            dir = SH_RIGHT;
        end else begin
            dir = SH_LEFT;
        end
    end

endmodule

// File: rtl/sash_left_path.sv
module sash_left_path #(
    parameter int DATA_W = 32,
    parameter int MAG_W  = 6
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [MAG_W-1:0]  mag,
    output logic [DATA_W-1:0] shl,
    output logic              lost
);

    logic [DATA_W-1:0] back;

    assign shl  = operand << mag;
    // Shifting back arithmetically must rebuild the operand when nothing significant was lost
    assign back = DATA_W'($signed(shl) >>> mag);
    assign lost = (back != operand);

endmodule

// File: rtl/sash_right_path.sv
module sash_right_path #(
    parameter int DATA_W = 32,
    parameter int MAG_W  = 6
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [MAG_W-1:0]  mag,
    output logic [DATA_W-1:0] shr
);

    localparam logic [MAG_W-1:0] FULL = MAG_W'(DATA_W);

    always_comb begin
        if (mag >= FULL) begin
            shr = {DATA_W{operand[DATA_W-1]}};
        end else begin
            shr = DATA_W'($signed(operand) >>> mag);
        end
    end

endmodule

// File: rtl/sat_ashift.sv
module sat_ashift
    import sash_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int CNT_USE = 6,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       operand,
    input  logic [15:0]       count,
    input  logic              sat_en,
    output logic [31:0]       result,
    output logic              ovf
);

    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    shift_dir_e         dir;
    logic [CNT_USE-1:0] mag;
    logic [DATA_W-1:0]  l_shl;
    logic               l_lost;
    logic [DATA_W-1:0]  r_shr;
    logic [DATA_W-1:0]  nxt_res;
    logic               nxt_ovf;

    sash_count_decode #(.CNT_W(CNT_W), .CNT_USE(CNT_USE)) u_dec (
        .count (count),
        .dir   (dir),
        .mag   (mag)
    );

    sash_left_path #(.DATA_W(DATA_W), .MAG_W(CNT_USE)) u_left (
        .operand (operand),
        .mag     (mag),
        .shl     (l_shl),
        .lost    (l_lost)
    );

    sash_right_path #(.DATA_W(DATA_W), .MAG_W(CNT_USE)) u_right (
        .operand (operand),
        .mag     (mag),
        .shr     (r_shr)
    );

    // Result select per direction
    always_comb begin
        unique case (dir)
            SH_HOLD: begin
                nxt_res = operand;
                nxt_ovf = 1'b0;
            end
            SH_RIGHT: begin
                nxt_res = r_shr;
                nxt_ovf = 1'b0;
            end
            SH_LEFT: begin
                nxt_ovf = l_lost;
                if (sat_en && l_lost) begin
                    nxt_res = operand[DATA_W-1] ? MIN_NEG : MAX_POS;
                end else begin
                    nxt_res = l_shl;
                end
            end
            default: begin
                nxt_res = operand;
                nxt_ovf = 1'b0;
            end
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result <= '0;
                    ovf    <= 1'b0;
                end else begin
                    result <= nxt_res;
                    ovf    <= nxt_ovf;
                end
            end

            // R8: registered outputs follow the selected value one edge later
            p_out_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (result == $past(nxt_res)) && (ovf == $past(nxt_ovf)));
        end else begin : g_comb
            assign result = nxt_res;
            assign ovf    = nxt_ovf;
        end
    endgenerate

    // R7: a zero field passes the operand through untouched
    p_hold_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count[CNT_USE-1:0] == '0) |-> (nxt_res == operand) && !nxt_ovf);

    // R5: right shifts never flag overflow
    p_right_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count[CNT_USE-1] |-> !nxt_ovf);

    // R2: arithmetic right shift keeps the sign
    p_right_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count[CNT_USE-1] |-> (nxt_res[DATA_W-1] == operand[DATA_W-1]));

    // R4: overflow with saturation clamps towards the operand's sign
    p_sat_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && nxt_ovf) |-> (nxt_res == (operand[DATA_W-1] ? MIN_NEG : MAX_POS)));

    // R3: with saturation on, a left shift never flips the sign
    p_sat_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && !count[CNT_USE-1]) |-> (nxt_res[DATA_W-1] == operand[DATA_W-1]));

endmodule

// File: tb/sat_ashift_bench.sv
module sat_ashift_bench;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand = 32'h1234_5678;
    logic [15:0] count = 16'd1;
    logic        sat_en = 1'b1;
    logic [31:0] result;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit running  = 1'b0;
    bit finished = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    sat_ashift u_sat_ashift (
        .clk     (clk),
        .rst_n   (rst_n),
        .operand (operand),
        .count   (count),
        .sat_en  (sat_en),
        .result  (result),
        .ovf     (ovf)
    );

    // Reference: 64-bit arithmetic on the low 6 bits of the count (R1)
    task automatic model(input logic [31:0] op, input logic [15:0] cnt, input logic sat,
                         output logic [31:0] res, output logic o);
        longint v;
        longint top;
        int n;
        v = longint'($signed(op));
        n = int'($signed(cnt[5:0]));
        o = 1'b0;
        if (n < 0) begin
            v = v >>> (-n);
            res = v[31:0];
        end else if (n == 0) begin
            res = op;
        end else begin
            v = v <<< n;
            top = v >>> 31;
            o = (top != 0) && (top != -1);
            if (sat && o) res = op[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else          res = v[31:0];
        end
    endtask

    task automatic drive_exp(input logic [31:0] op, input logic [15:0] cnt, input logic sat,
                             input logic [31:0] er, input logic eo, input string tag);
        exp_t e;
        @(negedge clk);
        operand = op;
        count   = cnt;
        sat_en  = sat;
        e.res = er;
        e.ovf = eo;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive_ref(input logic [31:0] op, input logic [15:0] cnt, input logic sat,
                             input string tag);
        logic [31:0] r;
        logic o;
        model(op, cnt, sat, r, o);
        drive_exp(op, cnt, sat, r, o, tag);
    endtask

    // Monitor: one result per edge while items are pending
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (running && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (result !== e.res || ovf !== e.ovf) begin
                    n_fail++;
                    $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                             e.tag, result, ovf, e.res, e.ovf);
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !finished) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8 watchdog: cycles=%0d expected below 20000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        end
    end

    logic [31:0] ops [8] = '{32'h1234_5678, 32'h8234_5678, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'h0000_0000, 32'hFFFF_FFFF, 32'h4000_0000, 32'hC000_0001};

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (result !== 32'h0 || ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset: result=%h ovf=%b expected result=00000000 ovf=0", result, ovf);
        end
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R2: arithmetic right shifts and sign fill
        drive_exp(32'h8234_5678, 16'hFFFA, 1'b1, 32'hFE08_D159, 1'b0, "R2 right by 6");
        drive_exp(32'hD789_ABCD, 16'hFFF2, 1'b1, 32'hFFFF_5E26, 1'b0, "R2 right by 14");
        drive_exp(32'h8000_0001, 16'hFFE0, 1'b1, 32'hFFFF_FFFF, 1'b0, "R2 right by 32 neg");
        drive_exp(32'h7FFF_FFFF, 16'hFFE0, 1'b0, 32'h0000_0000, 1'b0, "R2 right by 32 pos");
        // R3: exact left shifts
        drive_exp(32'h1234_5678, 16'd1,  1'b1, 32'h2468_ACF0, 1'b0, "R3 left by 1");
        drive_exp(32'h0000_000E, 16'd14, 1'b1, 32'h0003_8000, 1'b0, "R3 left by 14");
        drive_exp(32'hC000_0000, 16'd1,  1'b1, 32'h8000_0000, 1'b0, "R3 exact to min");
        // R4: clamps
        drive_exp(32'h3456_789A, 16'd5,  1'b1, 32'h7FFF_FFFF, 1'b1, "R4 clamp positive");
        drive_exp(32'h4000_0000, 16'd1,  1'b1, 32'h7FFF_FFFF, 1'b1, "R4 sign bit reached");
        drive_exp(32'h8000_0001, 16'd1,  1'b1, 32'h8000_0000, 1'b1, "R4 clamp negative");
        // R5: right shifts never overflow
        drive_exp(32'h4567_FFFF, 16'hFFFF, 1'b1, 32'h22B3_FFFF, 1'b0, "R5 right by 1");
        drive_exp(32'h0123_0002, 16'hFFF1, 1'b1, 32'h0000_0246, 1'b0, "R5 right by 15");
        // R6: wrap without saturation
        drive_exp(32'h3456_789A, 16'd5,  1'b0, 32'h8ACF_1340, 1'b1, "R6 wrap with flag");
        // R7: pass-through
        drive_exp(32'h89AB_CDEF, 16'd0,  1'b1, 32'h89AB_CDEF, 1'b0, "R7 zero count");
        // R1: upper count bits ignored
        drive_exp(32'h89AB_CDEF, 16'h0040, 1'b1, 32'h89AB_CDEF, 1'b0, "R1 field zero");
        drive_exp(32'h1234_5678, 16'hFFC5, 1'b1, 32'h7FFF_FFFF, 1'b1, "R1 high bits set");
        drive_exp(32'h0123_0002, 16'h003F, 1'b0, 32'h0091_8001, 1'b0, "R1 field minus one");

        // Exhaustive count sweep against the 64-bit model
        for (int c = -32; c <= 31; c++) begin
            for (int k = 0; k < 8; k++) begin
                for (int s = 0; s < 2; s++) begin
                    string t;
                    if (c < 0)       t = "R2 sweep";
                    else if (c == 0) t = "R7 sweep";
                    else if (s == 1) t = "R4 sweep";
                    else             t = "R6 sweep";
                    drive_ref(ops[k], c[15:0], s[0], t);
                end
            end
        end

        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule